// File: doc/BRIEF.md
# Byte-wide ROM word-assembly adapter

This block lets a 16-bit big-endian processor bus read one 8-bit boot ROM as if the ROM were a full word wide. For each processor read of the ROM region, a sequencer running on a fast clock makes two byte fetches. It fetches the odd byte first and keeps it in a holding register. It then fetches the even byte and passes it straight through. The processor sees the odd byte on the low data lane and the even byte on the high data lane, because the ROM data pins sit on the high lane. The data-acknowledge is raised at a fixed point in the cycle, so the processor needs no wait states.

Processor-side inputs are taken as synchronous to the fast clock. Writes into the ROM region are acknowledged but never touch the ROM output enable. Decoding the ROM region, driving the physical tri-state buffers and programming the device are done elsewhere. This block supplies a chip-select input and a data output-enable signal for those jobs.

Top module: `bwrom_word_adapter`

## Requirements
- R1: A full-word read of word address W returns, while the acknowledge is active, the byte at ROM address {W,1} on data bits 7..0 and the byte at ROM address {W,0} on data bits 15..8.
- R2: Each read makes exactly two ROM fetches while the output enable is low. The first is at the odd byte address {W,1} and the second is at the even byte address {W,0}. While the output enable stays low, the ROM address only ever changes from odd to even.
- R3: On a read, the active-low acknowledge first reads low after the (2*ROM_ACCESS_CYCLES+2)-th rising edge. The count starts at 1 with the edge that first samples the request, meaning address strobe low, chip select high and at least one data strobe low. With the default of 2 access cycles this is the 6th edge.
- R4: Each fetch holds its ROM address and output enable steady for at least ROM_ACCESS_CYCLES fast-clock cycles before the byte is used.
- R5: A read that asserts only the upper strobe, or only the lower strobe, still makes both fetches and presents the same 16-bit word as a full-word read.
- R6: A write (read/write line low) to the ROM region is acknowledged after the first rising edge. The ROM output enable and chip enable stay high for the whole cycle.
- R7: The data output enable is high only while chip select is high, the read/write line is high, the address strobe is low and at least one data strobe is low. Otherwise it is low.
- R8: While the acknowledge stays active, all 16 data output bits stay unchanged, for as long as the processor holds the address strobe.
- R9: The acknowledge goes inactive on the first rising edge after the address strobe is released. Once the strobe has been high for two samples, the ROM chip enable is high.
- R10: If the address strobe is released before the acknowledge, the cycle is abandoned and no acknowledge is produced for it.
- R11: During reset, the acknowledge, the ROM chip enable and the ROM output enable are all inactive (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | ADDR_W | Processor word address |
| cpu_sel_i | input | 1 | ROM region select, active high |
| cpu_as_ni | input | 1 | Address strobe, active low |
| cpu_uds_ni | input | 1 | Upper data strobe (bits 15..8), active low |
| cpu_lds_ni | input | 1 | Lower data strobe (bits 7..0), active low |
| cpu_rnw_i | input | 1 | High for read, low for write |
| cpu_data_o | output | 2*BYTE_W | Assembled word to processor |
| cpu_data_oe_o | output | 1 | Drive enable for cpu_data_o |
| cpu_ack_no | output | 1 | Data acknowledge, active low |
| rom_addr_o | output | ADDR_W+1 | ROM byte address |
| rom_ce_no | output | 1 | ROM chip enable, active low |
| rom_oe_no | output | 1 | ROM output enable, active low |
| rom_data_i | input | BYTE_W | ROM byte data |

## Verification
Word reads at random addresses use a ROM model whose odd and even bytes always differ. A swapped lane, a stale holding register or a wrong fetch order therefore shows up as a wrong word. Reads with only the upper strobe or only the lower strobe are mixed in to show that the strobe pattern does not shorten the two-fetch sequence. Writes, reads outside the selected region and reads with no strobe separate true reads from the cases that must leave the ROM and the data bus alone. Cycles abandoned before the acknowledge, and acknowledge windows held open for a random number of cycles, test the end-of-cycle handling and the stability of the data.

// File: rtl/bwrom_pkg.sv
package bwrom_pkg;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_FETCH_ODD  = 3'd1,
      ST_LATCH_ODD  = 3'd2,
      ST_FETCH_EVEN = 3'd3,
      ST_ACK        = 3'd4,
      ST_WAIT_END   = 3'd5
   } bwrom_state_e;

   function automatic int unsigned bwrom_ack_latency(input int unsigned access_cycles);
      return 2 * access_cycles + 2;
   endfunction

endpackage

// File: rtl/bwrom_fetch_timer.sv
module bwrom_fetch_timer #(
   parameter int unsigned ACCESS_CYCLES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic run_i,
   output logic done_o
);
   localparam int unsigned CNT_W = (ACCESS_CYCLES < 2) ? 1 : $clog2(ACCESS_CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ACCESS_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   assign done_o = (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (run_i && !done_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/bwrom_hold_path.sv
module bwrom_hold_path #(
   parameter int unsigned BYTE_W     = 8,
   parameter bit          CLEAR_HOLD = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                capture_i,
   input  logic                release_i,
   input  logic [BYTE_W-1:0]   rom_data_i,
   output logic [2*BYTE_W-1:0] word_o
);
   logic [BYTE_W-1:0] hold_q;

   generate
      if (CLEAR_HOLD) begin : g_clear
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               hold_q <= '0;
            end else if (capture_i) begin
               hold_q <= rom_data_i;
            end else if (release_i) begin
               hold_q <= '0;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               hold_q <= '0;
            end else if (capture_i) begin
               hold_q <= rom_data_i;
            end
         end
      end
   endgenerate

   // even byte passes straight to the high lane, captured odd byte to the low lane
   assign word_o = {rom_data_i, hold_q};

endmodule

// File: rtl/bwrom_sequencer.sv
module bwrom_sequencer
   import bwrom_pkg::*;
#(
   parameter int unsigned ACCESS_CYCLES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   input  logic as_ni,
   input  logic rnw_i,
   output logic odd_phase_o,
   output logic rom_en_o,
   output logic capture_o,
   output logic release_o,
   output logic ack_o
);
   bwrom_state_e state_q, state_d;
   logic         is_read_q;
   logic         tmr_done;
   logic         tmr_run;
   logic         tmr_clear;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:       if (req_i) state_d = rnw_i ? ST_FETCH_ODD : ST_ACK;
         ST_FETCH_ODD:  if (as_ni) state_d = ST_WAIT_END;
                        else if (tmr_done) state_d = ST_LATCH_ODD;
         ST_LATCH_ODD:  state_d = as_ni ? ST_WAIT_END : ST_FETCH_EVEN;
         ST_FETCH_EVEN: if (as_ni) state_d = ST_WAIT_END;
                        else if (tmr_done) state_d = ST_ACK;
         ST_ACK:        if (as_ni) state_d = ST_WAIT_END;
         ST_WAIT_END:   state_d = ST_IDLE;
         default:       state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_IDLE;
         is_read_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && req_i) begin
            is_read_q <= rnw_i;
         end
      end
   end

   assign tmr_run   = (state_q == ST_FETCH_ODD) || (state_q == ST_FETCH_EVEN);
   assign tmr_clear = (state_d != state_q);

   bwrom_fetch_timer #(
      .ACCESS_CYCLES (ACCESS_CYCLES)
   ) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (tmr_clear),
      .run_i   (tmr_run),
      .done_o  (tmr_done)
   );

   assign odd_phase_o = (state_q == ST_FETCH_ODD) || (state_q == ST_LATCH_ODD);
   assign rom_en_o    = is_read_q && (state_q inside {ST_FETCH_ODD, ST_LATCH_ODD,
                                                      ST_FETCH_EVEN, ST_ACK});
   assign capture_o   = (state_q == ST_LATCH_ODD);
   assign release_o   = (state_q == ST_WAIT_END);
   assign ack_o       = (state_q == ST_ACK);

endmodule

// File: rtl/bwrom_word_adapter.sv
module bwrom_word_adapter #(
   parameter int unsigned ADDR_W            = 15,
   parameter int unsigned BYTE_W            = 8,
   parameter int unsigned ROM_ACCESS_CYCLES = 2,
   parameter bit          CLEAR_HOLD        = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [ADDR_W-1:0]   cpu_addr_i,
   input  logic                cpu_sel_i,
   input  logic                cpu_as_ni,
   input  logic                cpu_uds_ni,
   input  logic                cpu_lds_ni,
   input  logic                cpu_rnw_i,
   output logic [2*BYTE_W-1:0] cpu_data_o,
   output logic                cpu_data_oe_o,
   output logic                cpu_ack_no,
   output logic [ADDR_W:0]     rom_addr_o,
   output logic                rom_ce_no,
   output logic                rom_oe_no,
   input  logic [BYTE_W-1:0]   rom_data_i
);
   localparam int unsigned WORD_W = 2 * BYTE_W;

   generate
      if (ROM_ACCESS_CYCLES < 1) begin : g_bad_access
         $error("ROM_ACCESS_CYCLES must be at least 1");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
      if (BYTE_W < 1) begin : g_bad_byte
         $error("BYTE_W must be at least 1");
      end
   endgenerate

   logic any_strobe;
   logic req;
   logic odd_phase;
   logic rom_en;
   logic capture;
   logic release_hold;
   logic ack;
   logic [WORD_W-1:0] word;

   assign any_strobe = ~(cpu_uds_ni & cpu_lds_ni);
   assign req        = cpu_sel_i & ~cpu_as_ni & any_strobe;

   bwrom_sequencer #(
      .ACCESS_CYCLES (ROM_ACCESS_CYCLES)
   ) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (req),
      .as_ni       (cpu_as_ni),
      .rnw_i       (cpu_rnw_i),
      .odd_phase_o (odd_phase),
      .rom_en_o    (rom_en),
      .capture_o   (capture),
      .release_o   (release_hold),
      .ack_o       (ack)
   );

   bwrom_hold_path #(
      .BYTE_W     (BYTE_W),
      .CLEAR_HOLD (CLEAR_HOLD)
   ) u_path (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .capture_i  (capture),
      .release_i  (release_hold),
      .rom_data_i (rom_data_i),
      .word_o     (word)
   );

   assign rom_addr_o    = {cpu_addr_i, odd_phase};
   assign rom_ce_no     = ~rom_en;
   assign rom_oe_no     = ~rom_en;
   assign cpu_ack_no    = ~ack;
   assign cpu_data_o    = word;
   assign cpu_data_oe_o = cpu_sel_i & cpu_rnw_i & ~cpu_as_ni & any_strobe;

endmodule

// File: rtl/bwrom_word_adapter_chk.sv
module bwrom_word_adapter_chk #(
   parameter int unsigned ADDR_W            = 15,
   parameter int unsigned WORD_W            = 16,
   parameter int unsigned ROM_ACCESS_CYCLES = 2
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              cpu_as_ni,
   input logic              cpu_rnw_i,
   input logic              cpu_ack_no,
   input logic [WORD_W-1:0] cpu_data_o,
   input logic [ADDR_W:0]   rom_addr_o,
   input logic              rom_ce_no,
   input logic              rom_oe_no
);
   localparam int unsigned LAT   = bwrom_pkg::bwrom_ack_latency(ROM_ACCESS_CYCLES);
   localparam int unsigned CNT_W = $clog2(LAT + 2) + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] as_cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         as_cnt_q <= '0;
      end else if (cpu_as_ni) begin
         as_cnt_q <= '0;
      end else if (as_cnt_q != CNT_MAX) begin
         as_cnt_q <= as_cnt_q + 1'b1;
      end
   end

   // R3: read acknowledge arrives at its fixed point in the cycle
   p_read_ack_time_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(cpu_ack_no) && cpu_rnw_i) |-> (as_cnt_q == CNT_W'(LAT)));

   // R6: a write is acknowledged after one edge
   p_write_ack_time_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(cpu_ack_no) && !cpu_rnw_i) |-> (as_cnt_q == CNT_W'(1)));

   // R6: no ROM output during a write cycle
   p_no_oe_on_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cpu_as_ni && !cpu_rnw_i) |-> (rom_oe_no && rom_ce_no));

   // R2: while output enable stays low, the address only moves odd -> even
   p_fetch_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rom_oe_no && $past(!rom_oe_no) && (rom_addr_o != $past(rom_addr_o)))
      |-> (!rom_addr_o[0] && $past(rom_addr_o[0])));

   // R8: data held steady through the acknowledge window
   p_data_steady_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cpu_ack_no && $past(!cpu_ack_no)) |-> $stable(cpu_data_o));

   // R9: acknowledge withdrawn one edge after the strobe is released
   p_ack_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cpu_as_ni) |=> cpu_ack_no);

   // R9: ROM quiet once the strobe has been high for two samples
   p_rom_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_as_ni && $past(cpu_as_ni)) |-> (rom_ce_no && rom_oe_no && cpu_ack_no));

endmodule

bind bwrom_word_adapter bwrom_word_adapter_chk #(
   .ADDR_W            (ADDR_W),
   .WORD_W            (2 * BYTE_W),
   .ROM_ACCESS_CYCLES (ROM_ACCESS_CYCLES)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .cpu_as_ni  (cpu_as_ni),
   .cpu_rnw_i  (cpu_rnw_i),
   .cpu_ack_no (cpu_ack_no),
   .cpu_data_o (cpu_data_o),
   .rom_addr_o (rom_addr_o),
   .rom_ce_no  (rom_ce_no),
   .rom_oe_no  (rom_oe_no)
);

// File: tb/bwrom_word_adapter_tb_top.sv
`timescale 1ns/1ps
module bwrom_word_adapter_tb_top;
   localparam int unsigned ADDR_W = 15;
   localparam int unsigned ACC    = 2;
   localparam int unsigned LAT    = 2 * ACC + 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] cpu_addr = '0;
   logic        cpu_sel = 1'b0;
   logic        cpu_as_n = 1'b1;
   logic        cpu_uds_n = 1'b1;
   logic        cpu_lds_n = 1'b1;
   logic        cpu_rnw = 1'b1;
   logic [15:0] cpu_data;
   logic        cpu_data_oe;
   logic        cpu_ack_n;
   logic [15:0] rom_addr;
   logic        rom_ce_n;
   logic        rom_oe_n;
   logic [7:0]  rom_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   function automatic logic [7:0] rom_byte(input logic [15:0] a);
      return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
   endfunction

   function automatic logic [15:0] exp_word(input logic [14:0] w);
      return {rom_byte({w, 1'b0}), rom_byte({w, 1'b1})};
   endfunction

   assign rom_data = (!rom_ce_n && !rom_oe_n) ? rom_byte(rom_addr) : 8'hFF;

   bwrom_word_adapter #(
      .ADDR_W            (ADDR_W),
      .BYTE_W            (8),
      .ROM_ACCESS_CYCLES (ACC),
      .CLEAR_HOLD        (1'b1)
   ) dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .cpu_addr_i    (cpu_addr),
      .cpu_sel_i     (cpu_sel),
      .cpu_as_ni     (cpu_as_n),
      .cpu_uds_ni    (cpu_uds_n),
      .cpu_lds_ni    (cpu_lds_n),
      .cpu_rnw_i     (cpu_rnw),
      .cpu_data_o    (cpu_data),
      .cpu_data_oe_o (cpu_data_oe),
      .cpu_ack_no    (cpu_ack_n),
      .rom_addr_o    (rom_addr),
      .rom_ce_no     (rom_ce_n),
      .rom_oe_no     (rom_oe_n),
      .rom_data_i    (rom_data)
   );

   // fetch monitor: counts separate ROM fetches and their addresses
   int          fetch_cnt = 0;
   int          oe_low_cyc = 0;
   int          run_len = 0;
   int          min_run = 1000;
   logic [15:0] fetch_a [2];
   logic        prev_oe_n = 1'b1;
   logic [15:0] prev_addr = '0;

   always @(posedge clk) begin
      cycles = cycles + 1;
      if (!rom_oe_n) begin
         oe_low_cyc = oe_low_cyc + 1;
         if (prev_oe_n || rom_addr != prev_addr) begin
            if (fetch_cnt > 0 && run_len < min_run) min_run = run_len;
            if (fetch_cnt < 2) fetch_a[fetch_cnt] = rom_addr;
            fetch_cnt = fetch_cnt + 1;
            run_len = 1;
         end else begin
            run_len = run_len + 1;
         end
      end
      prev_oe_n = rom_oe_n;
      prev_addr = rom_addr;
   end

   task automatic clr_mon();
      fetch_cnt = 0;
      oe_low_cyc = 0;
      run_len = 0;
      min_run = 1000;
   endtask

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic end_cycle();
      cpu_as_n  = 1'b1;
      cpu_uds_n = 1'b1;
      cpu_lds_n = 1'b1;
      tick();
      check(cpu_ack_n == 1'b1, "R9 ack release", 32'(cpu_ack_n), 32'd1);
      check(cpu_data_oe == 1'b0, "R7 oe after strobe", 32'(cpu_data_oe), 32'd0);
      tick();
      check(rom_ce_n == 1'b1, "R9 ce idle", 32'(rom_ce_n), 32'd1);
      cpu_sel = 1'b0;
      tick();
   endtask

   // strobe mode: 0 both, 1 upper only, 2 lower only
   task automatic do_read(input logic [14:0] a, input int mode, input int extra);
      int          n;
      logic [15:0] first;
      @(negedge clk);
      clr_mon();
      cpu_addr  = a;
      cpu_sel   = 1'b1;
      cpu_rnw   = 1'b1;
      cpu_as_n  = 1'b0;
      cpu_uds_n = (mode == 2);
      cpu_lds_n = (mode == 1);
      n = 0;
      do begin
         tick();
         n++;
      end while (cpu_ack_n && n < 40);
      check(n == LAT, "R3 read ack edge", 32'(n), 32'(LAT));
      check(cpu_data_oe == 1'b1, "R7 oe during read", 32'(cpu_data_oe), 32'd1);
      if (mode == 0)
         check(cpu_data == exp_word(a), "R1 word data", 32'(cpu_data), 32'(exp_word(a)));
      else
         check(cpu_data == exp_word(a), "R5 single strobe data", 32'(cpu_data),
               32'(exp_word(a)));
      first = cpu_data;
      for (int k = 0; k < extra; k++) begin
         tick();
         check(cpu_ack_n == 1'b0 && cpu_data == first, "R8 held data", 32'(cpu_data),
               32'(first));
      end
      check(fetch_cnt == 2, (mode == 0) ? "R2 fetch count" : "R5 fetch count",
            32'(fetch_cnt), 32'd2);
      check(fetch_a[0] == {a, 1'b1}, "R2 first fetch odd", 32'(fetch_a[0]), 32'({a, 1'b1}));
      check(fetch_a[1] == {a, 1'b0}, "R2 second fetch even", 32'(fetch_a[1]),
            32'({a, 1'b0}));
      check(min_run >= ACC, "R4 fetch hold cycles", 32'(min_run), 32'(ACC));
      end_cycle();
   endtask

   task automatic do_write(input logic [14:0] a);
      int n;
      @(negedge clk);
      clr_mon();
      cpu_addr  = a;
      cpu_sel   = 1'b1;
      cpu_rnw   = 1'b0;
      cpu_as_n  = 1'b0;
      cpu_uds_n = 1'b0;
      cpu_lds_n = 1'b0;
      n = 0;
      do begin
         tick();
         n++;
      end while (cpu_ack_n && n < 40);
      check(n == 1, "R6 write ack edge", 32'(n), 32'd1);
      check(cpu_data_oe == 1'b0, "R7 no drive on write", 32'(cpu_data_oe), 32'd0);
      tick();
      check(oe_low_cyc == 0 && rom_ce_n, "R6 rom untouched", 32'(oe_low_cyc), 32'd0);
      end_cycle();
      cpu_rnw = 1'b1;
   endtask

   task automatic do_abort(input logic [14:0] a, input int hold);
      int acks;
      @(negedge clk);
      cpu_addr  = a;
      cpu_sel   = 1'b1;
      cpu_rnw   = 1'b1;
      cpu_as_n  = 1'b0;
      cpu_uds_n = 1'b0;
      cpu_lds_n = 1'b0;
      for (int k = 0; k < hold; k++) tick();
      cpu_as_n  = 1'b1;
      cpu_uds_n = 1'b1;
      cpu_lds_n = 1'b1;
      acks = 0;
      for (int k = 0; k < 10; k++) begin
         tick();
         if (!cpu_ack_n) acks++;
      end
      check(acks == 0, "R10 no ack after abort", 32'(acks), 32'd0);
      check(rom_ce_n == 1'b1, "R10 rom idle after abort", 32'(rom_ce_n), 32'd1);
      cpu_sel = 1'b0;
      tick();
   endtask

   initial begin
      void'($urandom(32'd24680));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11: reset state
      check(cpu_ack_n == 1'b1, "R11 ack in reset", 32'(cpu_ack_n), 32'd1);
      check(rom_ce_n == 1'b1, "R11 ce in reset", 32'(rom_ce_n), 32'd1);
      check(rom_oe_n == 1'b1, "R11 oe in reset", 32'(rom_oe_n), 32'd1);
      check(cpu_data_oe == 1'b0, "R11 data oe in reset", 32'(cpu_data_oe), 32'd0);
      rst_n = 1'b1;
      tick();

      // directed corners
      do_read(15'h0000, 0, 0);
      do_read(15'h7FFF, 0, 3);
      do_read(15'h1234, 1, 1);
      do_read(15'h1234, 2, 0);
      do_write(15'h0042);
      do_abort(15'h0100, 1);
      do_abort(15'h0101, ACC + 2);
      do_read(15'h0101, 0, 0);

      // R7: region not selected, then no strobe: nothing driven, no ROM activity
      @(negedge clk);
      clr_mon();
      cpu_addr = 15'h0055;
      cpu_sel  = 1'b0;
      cpu_rnw  = 1'b1;
      cpu_as_n = 1'b0;
      cpu_uds_n = 1'b0;
      cpu_lds_n = 1'b0;
      repeat (LAT + 2) tick();
      check(cpu_data_oe == 1'b0, "R7 unselected no drive", 32'(cpu_data_oe), 32'd0);
      check(cpu_ack_n == 1'b1 && oe_low_cyc == 0, "R7 unselected no ack",
            32'(oe_low_cyc), 32'd0);
      cpu_sel   = 1'b1;
      cpu_uds_n = 1'b1;
      cpu_lds_n = 1'b1;
      repeat (LAT + 2) tick();
      check(cpu_data_oe == 1'b0, "R7 no strobe no drive", 32'(cpu_data_oe), 32'd0);
      check(cpu_ack_n == 1'b1, "R7 no strobe no ack", 32'(cpu_ack_n), 32'd1);
      cpu_as_n = 1'b1;
      cpu_sel  = 1'b0;
      repeat (2) tick();

      // constrained random mix
      for (int i = 0; i < 60; i++) begin
         int kind;
         kind = int'($urandom % 8);
         if (kind == 0) do_write(15'($urandom));
         else do_read(15'($urandom), int'($urandom % 3), int'($urandom % 4));
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule